// File: doc/BRIEF.md
# PPS-Latched Timekeeper

This block keeps absolute time as a seconds count together with a count of master-clock ticks inside the current second. The ticks counter runs from zero to one less than a ticks-per-second parameter; when it wraps, the seconds counter advances by one.

Software sets the time by writing a pending seconds value and a pending ticks value through a small write port. Writing the ticks value is the trigger. In deferred mode the write arms a load, and the counters take the pending pair on the next chosen edge of a pulse-per-second input. In immediate mode the counters take the pair on the write itself. Two pulse inputs are available: one from an external connector and one from a board-to-board link. A flag picks the source and another flag picks the edge. Each selected edge also raises a one-cycle interrupt pulse. A read request captures both counters in the same cycle, so that software sees a matching seconds and ticks pair.

Top module: `pps_timekeeper`

## Requirements
- R1: After reset both counters, both snapshot outputs and `ppsIrq` are zero. The edge flag selects falling, the source flag selects the external input, deferred mode is active and no load is armed.
- R2: Ticks advance by one each clock from 0 to TICKS_PER_SEC-1. On the cycle after TICKS_PER_SEC-1, ticks read 0 and seconds have grown by one.
- R3: `rdReq` high at a rising clock edge copies the seconds and ticks counters, as they stand at that edge, into `rdSecs` and `rdTicks`. The outputs then hold until the next request.
- R4: Register addresses are 0 for pending seconds, 1 for pending ticks, 2 for flags and 3 for the mode. In the flags register, bit 0 selects the edge and bit 1 selects the source. In the mode register, bit 0 set means immediate. A write to pending seconds alone arms nothing.
- R5: In deferred mode a pending-ticks write arms a load. The next selected pulse edge loads the pending pair. The loaded values are present at the third rising clock edge after the input changes.
- R6: An armed load is consumed by exactly one commit. Later pulse edges do not reload the counters.
- R7: In immediate mode a pending-ticks write loads the pending seconds and the written ticks at the edge of the write, and leaves no load armed.
- R8: An edge flag of 0 commits on falling pulse edges and an edge flag of 1 commits on rising edges. The opposite edge neither commits nor raises `ppsIrq`.
- R9: A source flag of 0 uses `ppsExt` and a source flag of 1 uses `ppsLink`. Edges on the input that is not selected are ignored.
- R10: `ppsIrq` is high for exactly one cycle for each selected edge, whether or not a load is armed. It rises at the same clock edge as the commit.
- R11: Without an armed load, a selected pulse edge leaves the counters running undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register write address |
| regWrData | input | REG_W | Register write data |
| rdReq | input | 1 | Capture counters into the snapshot outputs |
| ppsExt | input | 1 | Pulse-per-second from the external connector (asynchronous) |
| ppsLink | input | 1 | Pulse-per-second from the board-to-board link (asynchronous) |
| rdSecs | output | SECS_W | Captured seconds |
| rdTicks | output | TICKS_W | Captured ticks |
| ppsIrq | output | 1 | One-cycle pulse on each selected edge |

## Verification
The hardest case to reach from the ports is the commit itself. It needs an armed load to meet a selected edge on the selected source after two synchronizer stages, and it must then be told apart from edges that have the wrong polarity or come from the other input. The stimulus arms a load first. It then drives the ignored edge and confirms through a snapshot that the counters were not reloaded. After that it drives the right edge and takes a snapshot on the cycle after `ppsIrq` rises, where the captured pair must equal the pending values exactly. A further edge after the commit shows that the load was used only once.

// File: rtl/tk_pkg.sv
package tk_pkg;

  typedef enum logic [1:0] {
    ADDR_PEND_SECS  = 2'd0,
    ADDR_PEND_TICKS = 2'd1,
    ADDR_FLAGS      = 2'd2,
    ADDR_MODE       = 2'd3
  } tkAddr_e;

  typedef struct packed {
    logic loadTime;
    logic captureRead;
  } tkStrobe_t;

  localparam int SRC_EXT  = 0;
  localparam int SRC_LINK = 1;
  localparam int NUM_SRC  = 2;

endpackage

// File: rtl/tk_ctrl.sv
module tk_ctrl
  import tk_pkg::*;
#(
  parameter int SECS_W  = 32,
  parameter int TICKS_W = 32,
  parameter int REG_W   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [1:0]          regAddr,
  input  logic [REG_W-1:0]    regWrData,
  input  logic                rdReq,
  input  logic [NUM_SRC-1:0]  ppsIn,
  output tkStrobe_t           strobe,
  output logic [SECS_W-1:0]   loadSecs,
  output logic [TICKS_W-1:0]  loadTicks,
  output logic                ppsIrq
);

  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [SECS_W-1:0]  pendSecs;
  logic [TICKS_W-1:0] pendTicks;
  logic               edgeRise;
  logic               srcLink;
  logic               immMode;
  logic               armed;
  logic [NUM_SRC-1:0] riseDet;
  logic [NUM_SRC-1:0] fallDet;
  logic               ppsEdge;
  logic               tickWrite;

  // per-source synchronizer and edge detector
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [PIPE_W-1:0] pipeQ;
    always_ff @(posedge clk) begin
      if (!rstN) pipeQ <= '0;
      else       pipeQ <= {pipeQ[PIPE_W-2:0], ppsIn[s]};
    end
    assign riseDet[s] = pipeQ[PIPE_W-2] & ~pipeQ[PIPE_W-1];
    assign fallDet[s] = ~pipeQ[PIPE_W-2] & pipeQ[PIPE_W-1];
  end

  always_comb begin
    if (srcLink) ppsEdge = edgeRise ? riseDet[SRC_LINK] : fallDet[SRC_LINK];
    else         ppsEdge = edgeRise ? riseDet[SRC_EXT]  : fallDet[SRC_EXT];
  end

  assign tickWrite = regWrEn && (regAddr == ADDR_PEND_TICKS);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSecs  <= '0;
      pendTicks <= '0;
      edgeRise  <= 1'b0;
      srcLink   <= 1'b0;
      immMode   <= 1'b0;
      armed     <= 1'b0;
      ppsIrq    <= 1'b0;
    end else begin
      ppsIrq <= ppsEdge;
      if (regWrEn) begin
        case (regAddr)
          ADDR_PEND_SECS:  pendSecs  <= regWrData[SECS_W-1:0];
          ADDR_PEND_TICKS: pendTicks <= regWrData[TICKS_W-1:0];
          ADDR_FLAGS: begin
            edgeRise <= regWrData[0];
            srcLink  <= regWrData[1];
          end
          default:         immMode   <= regWrData[0];
        endcase
      end
      if (tickWrite)             armed <= !immMode;
      else if (armed && ppsEdge) armed <= 1'b0;
    end
  end

  always_comb begin
    strobe.loadTime    = (tickWrite && immMode) || (!tickWrite && armed && ppsEdge);
    strobe.captureRead = rdReq;
    loadSecs           = pendSecs;
    loadTicks          = tickWrite ? regWrData[TICKS_W-1:0] : pendTicks;
  end

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    (armed && ppsEdge && !tickWrite) |=> !armed);  // R6

  AST_IMM_NO_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (tickWrite && immMode) |=> !armed);  // R7

  AST_SECS_NO_ARM: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && regWrEn && regAddr == ADDR_PEND_SECS) |=> !armed);  // R4

endmodule

// File: rtl/tk_datapath.sv
module tk_datapath
  import tk_pkg::*;
#(
  parameter int SECS_W        = 32,
  parameter int TICKS_W       = 32,
  parameter int TICKS_PER_SEC = 100_000_000
) (
  input  logic               clk,
  input  logic               rstN,
  input  tkStrobe_t          strobe,
  input  logic [SECS_W-1:0]  loadSecs,
  input  logic [TICKS_W-1:0] loadTicks,
  output logic [SECS_W-1:0]  rdSecs,
  output logic [TICKS_W-1:0] rdTicks
);

  localparam logic [TICKS_W-1:0] TICK_LAST = TICKS_W'(TICKS_PER_SEC - 1);

  logic [SECS_W-1:0]  secsQ;
  logic [TICKS_W-1:0] ticksQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secsQ  <= '0;
      ticksQ <= '0;
    end else if (strobe.loadTime) begin
      secsQ  <= loadSecs;
      ticksQ <= loadTicks;
    end else if (ticksQ == TICK_LAST) begin
      secsQ  <= secsQ + 1'b1;
      ticksQ <= '0;
    end else begin
      ticksQ <= ticksQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdSecs  <= '0;
      rdTicks <= '0;
    end else if (strobe.captureRead) begin
      rdSecs  <= secsQ;
      rdTicks <= ticksQ;
    end
  end

  AST_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadTime && ticksQ == TICK_LAST) |=>
      (ticksQ == '0 && secsQ == $past(secsQ) + 1'b1));  // R2

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.captureRead |=> ($stable(rdSecs) && $stable(rdTicks)));  // R3

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTime |=> (secsQ == $past(loadSecs) && ticksQ == $past(loadTicks)));  // R5

endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper
  import tk_pkg::*;
#(
  parameter int SECS_W        = 32,
  parameter int TICKS_W       = 32,
  parameter int REG_W         = 32,
  parameter int TICKS_PER_SEC = 100_000_000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [REG_W-1:0]   regWrData,
  input  logic               rdReq,
  input  logic               ppsExt,
  input  logic               ppsLink,
  output logic [SECS_W-1:0]  rdSecs,
  output logic [TICKS_W-1:0] rdTicks,
  output logic               ppsIrq
);

  tkStrobe_t          strobe;
  logic [SECS_W-1:0]  loadSecs;
  logic [TICKS_W-1:0] loadTicks;
  logic [NUM_SRC-1:0] ppsIn;

  assign ppsIn[SRC_EXT]  = ppsExt;
  assign ppsIn[SRC_LINK] = ppsLink;

  tk_ctrl #(
    .SECS_W(SECS_W), .TICKS_W(TICKS_W), .REG_W(REG_W), .SYNC_STAGES(2)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .rdReq(rdReq), .ppsIn(ppsIn), .strobe(strobe),
    .loadSecs(loadSecs), .loadTicks(loadTicks), .ppsIrq(ppsIrq)
  );

  tk_datapath #(
    .SECS_W(SECS_W), .TICKS_W(TICKS_W), .TICKS_PER_SEC(TICKS_PER_SEC)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadSecs(loadSecs),
    .loadTicks(loadTicks), .rdSecs(rdSecs), .rdTicks(rdTicks)
  );

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (ppsIrq && $stable(ppsExt) && $stable(ppsLink)) |=> !ppsIrq);  // R10

endmodule

// File: tb/test_pps_timekeeper.sv
module test_pps_timekeeper;

  localparam int TPS = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        rdReq = 1'b0;
  logic        ppsExt = 1'b0;
  logic        ppsLink = 1'b0;
  logic [31:0] rdSecs;
  logic [31:0] rdTicks;
  logic        ppsIrq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  pps_timekeeper #(.TICKS_PER_SEC(TPS)) i_pps_timekeeper (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .rdReq(rdReq), .ppsExt(ppsExt), .ppsLink(ppsLink),
    .rdSecs(rdSecs), .rdTicks(rdTicks), .ppsIrq(ppsIrq)
  );

  task automatic chkEq(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkNe(string req, logic [63:0] act, logic [63:0] notExp);
    nChecks++;
    if (act === notExp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected anything but %0h", req, act, notExp);
    end
  endtask

  // all tasks start and end on a falling clock edge
  task automatic wr(logic [1:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic snap();
    rdReq = 1'b1;
    @(negedge clk);
    rdReq = 1'b0;
  endtask

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chkEq("R1 irq", {63'd0, ppsIrq}, 64'd0);
    chkEq("R1 snapshot", {rdSecs, rdTicks}, 64'd0);
    snap();
    chkEq("R1 counters", {rdSecs, rdTicks}, 64'd0);
    snap();
    chkEq("R2 count", {rdSecs, rdTicks}, {32'd0, 32'd1});
  endtask

  task automatic t_imm_wrap();
    wr(2'd0, 32'd5);
    wr(2'd3, 32'd1);
    wr(2'd1, 32'd8);
    snap();
    chkEq("R7 immediate load", {rdSecs, rdTicks}, {32'd5, 32'd8});
    snap();
    chkEq("R2 last tick", {rdSecs, rdTicks}, {32'd5, 32'd9});
    snap();
    chkEq("R2 wrap", {rdSecs, rdTicks}, {32'd6, 32'd0});
    waitCyc(2);
    chkEq("R3 hold", {rdSecs, rdTicks}, {32'd6, 32'd0});
    wr(2'd3, 32'd0);
  endtask

  task automatic t_ext_falling();
    wr(2'd0, 32'd40);
    wr(2'd1, 32'd3);
    ppsExt = 1'b1;
    waitCyc(3);
    chkEq("R8 rising ignored irq", {63'd0, ppsIrq}, 64'd0);
    snap();
    chkNe("R8 rising no load", {rdSecs, rdTicks}, {32'd40, 32'd3});
    ppsExt = 1'b0;
    waitCyc(2);
    chkEq("R10 irq not early", {63'd0, ppsIrq}, 64'd0);
    waitCyc(1);
    chkEq("R10 irq rises", {63'd0, ppsIrq}, 64'd1);
    snap();
    chkEq("R5 committed", {rdSecs, rdTicks}, {32'd40, 32'd3});
    chkEq("R10 irq one cycle", {63'd0, ppsIrq}, 64'd0);
    ppsExt = 1'b1;
    waitCyc(3);
    ppsExt = 1'b0;
    waitCyc(3);
    chkEq("R10 irq without arm", {63'd0, ppsIrq}, 64'd1);
    snap();
    chkNe("R6 no second commit", {rdSecs, rdTicks}, {32'd40, 32'd3});
  endtask

  task automatic t_secs_only();
    wr(2'd0, 32'd90);
    ppsExt = 1'b1;
    waitCyc(3);
    ppsExt = 1'b0;
    waitCyc(3);
    chkEq("R11 irq", {63'd0, ppsIrq}, 64'd1);
    snap();
    chkNe("R11 R4 secs write arms nothing", {32'd0, rdSecs}, {32'd0, 32'd90});
  endtask

  task automatic t_link_rising();
    wr(2'd2, 32'd3);
    wr(2'd0, 32'd123);
    wr(2'd1, 32'd7);
    ppsExt = 1'b1;
    waitCyc(3);
    chkEq("R9 ext ignored irq", {63'd0, ppsIrq}, 64'd0);
    snap();
    chkNe("R9 ext no load", {32'd0, rdSecs}, {32'd0, 32'd123});
    ppsExt = 1'b0;
    waitCyc(3);
    chkEq("R9 ext fall ignored", {63'd0, ppsIrq}, 64'd0);
    ppsLink = 1'b1;
    waitCyc(3);
    chkEq("R8 link rising irq", {63'd0, ppsIrq}, 64'd1);
    snap();
    chkEq("R9 link commit", {rdSecs, rdTicks}, {32'd123, 32'd7});
    ppsLink = 1'b0;
    waitCyc(3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    waitCyc(4);
    rstN = 1'b1;
    t_reset();
    t_imm_wrap();
    t_ext_falling();
    t_secs_only();
    t_link_rising();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule